// File: doc/BRIEF.md
# Rotary wheel printer sequencer

This controller sets up one line on an eight-column numeric printer. Each column is a print wheel with twelve glyph positions: the digits 0 to 9, a decimal point and a dash. The controller rotates one wheel at a time, starting from the leftmost. The host picks a glyph for a wheel by asserting a block input after it has seen the right number of step pulses. The controller does not take glyph codes as data.

If the host never blocks a wheel, the controller issues twelve pulses (one full revolution) and moves on to the next wheel. When all eight wheels are set, the controller raises a ready flag and waits for a hammer command from the host. It then drives the hammer for a fixed time, drives the paper feed for a fixed time, and starts the next line from the leftmost wheel. A divider input sets the spacing of the step pulses.

Top module: `wheel_printer_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `step_o`, `ready_o`, `hammer_o` and `feed_o` are low and `wheel_o` is 0. The controller comes out of reset spinning wheel 0.
- R2: Each step pulse on `step_o` is one cycle wide. When wheel w (0 = leftmost) starts spinning, its first pulse comes `step_div_i` cycles after the first cycle in which `wheel_o` shows w. Later pulses for the same wheel are `step_div_i`+1 cycles apart. `step_div_i` must be at least 1.
- R3: If `block_i` is high at a clock edge while a wheel spins, that wheel gets no more pulses and the next wheel starts at that edge. If `block_i` is high from the first cycle a wheel is shown, that wheel gets zero pulses.
- R4: A wheel that is never blocked gets exactly 12 pulses. The next wheel starts at the edge that ends the twelfth pulse.
- R5: Wheels are stepped in the order 0, 1, …, 7. `wheel_o` holds the index of the wheel being stepped, and every step pulse belongs to the wheel that `wheel_o` shows in that cycle.
- R6: When wheel 7 stops, `ready_o` goes high and `wheel_o` stays at 7. `ready_o` stays high until `fire_i` is sampled high. While `ready_o` is high there are no step pulses, and `block_i` has no effect.
- R7: `fire_i` has no effect unless `ready_o` is high. While wheels spin it never raises `hammer_o`.
- R8: `fire_i` sampled high while `ready_o` is high makes `hammer_o` go high in the next cycle. `hammer_o` then stays high for exactly HAMMER_CYC cycles (default 4), and `ready_o` drops.
- R9: `feed_o` goes high in the cycle after `hammer_o` falls and stays high for exactly FEED_CYC cycles (default 6). After that the controller spins wheel 0 again, with `wheel_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_div_i | input | DIV_W (8) | Step pulse period minus one, in cycles |
| block_i | input | 1 | Host stop request for the current wheel |
| fire_i | input | 1 | Host hammer command |
| step_o | output | 1 | One-cycle step pulse for the selected wheel |
| wheel_o | output | clog2(NUM_WHEELS) (3) | Index of the selected wheel |
| ready_o | output | 1 | All wheels set, waiting for the hammer command |
| hammer_o | output | 1 | Hammer drive |
| feed_o | output | 1 | Paper feed drive |

## Verification
The embedded assertions check the following on every cycle:
- step pulses are one cycle wide;
- the wheel index only ever advances by one or returns to 0;
- the ready flag holds until a hammer command arrives;
- the hammer rises only from the ready state on a command;
- the feed follows the hammer directly;
- the line restarts at wheel 0.

The bench scenarios cover what no cycle-local property can express:
- the exact pulse count per wheel for a given blocking pattern, including zero pulses and a full revolution with no block;
- the pulse timing for different divider settings;
- the hold lengths of the hammer and the feed;
- that block and fire requests arriving in the wrong state change nothing at the outputs.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    ST_SPIN   = 2'd0,
    ST_READY  = 2'd1,
    ST_HAMMER = 2'd2,
    ST_FEED   = 2'd3
  } wp_state_e;
endpackage

// File: rtl/wp_step_timer.sv
module wp_step_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!run_i || clr_i || tick_o)   cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/wp_wheel_track.sv
module wp_wheel_track #(
  parameter int NUM_WHEELS = 8,
  parameter int NUM_POS    = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          restart_i,
  input  logic                          adv_i,
  input  logic                          step_i,
  output logic [$clog2(NUM_WHEELS)-1:0] wheel_o,
  output logic                          last_wheel_o,
  output logic                          last_pos_o
);
  localparam int WW = $clog2(NUM_WHEELS);
  localparam int PW = $clog2(NUM_POS);

  logic [WW-1:0] wheel_q;
  logic [PW-1:0] pos_q;

  assign wheel_o      = wheel_q;
  assign last_wheel_o = (wheel_q == WW'(NUM_WHEELS - 1));
  assign last_pos_o   = (pos_q == PW'(NUM_POS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wheel_q <= '0;
      pos_q   <= '0;
    end else if (restart_i) begin
      wheel_q <= '0;
      pos_q   <= '0;
    end else if (adv_i) begin
      wheel_q <= wheel_q + 1'b1;
      pos_q   <= '0;
    end else if (step_i) begin
      pos_q   <= pos_q + 1'b1;
    end
  end

  // R4: a plain step never runs past the last glyph
  pos_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !adv_i && !restart_i) |-> !last_pos_o);
endmodule

// File: rtl/wp_hold_timer.sv
module wp_hold_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // R8
  hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_i > CW'(1)) |=> !done_o);
endmodule

// File: rtl/wheel_printer_seq.sv
module wheel_printer_seq
  import wp_pkg::*;
#(
  parameter int NUM_WHEELS = 8,
  parameter int NUM_POS    = 12,
  parameter int DIV_W      = 8,
  parameter int HAMMER_CYC = 4,
  parameter int FEED_CYC   = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DIV_W-1:0]              step_div_i,
  input  logic                          block_i,
  input  logic                          fire_i,
  output logic                          step_o,
  output logic [$clog2(NUM_WHEELS)-1:0] wheel_o,
  output logic                          ready_o,
  output logic                          hammer_o,
  output logic                          feed_o
);
  localparam int WW       = $clog2(NUM_WHEELS);
  localparam int HOLD_MAX = (HAMMER_CYC > FEED_CYC) ? HAMMER_CYC : FEED_CYC;
  localparam int HW       = $clog2(HOLD_MAX + 1);

  wp_state_e     state_q, state_d;
  logic          tick, adv, last_wheel, last_pos, restart;
  logic          hold_start, hold_done;
  logic [HW-1:0] hold_len;
  logic [WW-1:0] wheel;

  wire spinning = (state_q == ST_SPIN);

  // block wins; a full revolution also ends the wheel
  assign adv = spinning && (block_i || (tick && last_pos));

  wp_step_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (spinning),
    .clr_i  (adv),
    .div_i  (step_div_i),
    .tick_o (tick)
  );

  wp_wheel_track #(.NUM_WHEELS(NUM_WHEELS), .NUM_POS(NUM_POS)) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart),
    .adv_i        (adv && !last_wheel),
    .step_i       (tick && !adv),
    .wheel_o      (wheel),
    .last_wheel_o (last_wheel),
    .last_pos_o   (last_pos)
  );

  wp_hold_timer #(.CW(HW)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (hold_start),
    .len_i   (hold_len),
    .done_o  (hold_done)
  );

  always_comb begin
    state_d    = state_q;
    hold_start = 1'b0;
    hold_len   = HW'(HAMMER_CYC);
    restart    = 1'b0;
    unique case (state_q)
      ST_SPIN:   if (adv && last_wheel) state_d = ST_READY;
      ST_READY:  if (fire_i) begin
                   state_d    = ST_HAMMER;
                   hold_start = 1'b1;
                   hold_len   = HW'(HAMMER_CYC);
                 end
      ST_HAMMER: if (hold_done) begin
                   state_d    = ST_FEED;
                   hold_start = 1'b1;
                   hold_len   = HW'(FEED_CYC);
                 end
      ST_FEED:   if (hold_done) begin
                   state_d = ST_SPIN;
                   restart = 1'b1;
                 end
      default:   state_d = ST_SPIN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SPIN;
    else         state_q <= state_d;
  end

  assign step_o   = tick;
  assign wheel_o  = wheel;
  assign ready_o  = (state_q == ST_READY);
  assign hammer_o = (state_q == ST_HAMMER);
  assign feed_o   = (state_q == ST_FEED);

  // R5
  wheel_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wheel_o) |-> (wheel_o == $past(wheel_o) + 1'b1 || wheel_o == '0));
  // R6
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !fire_i) |=> (ready_o && !step_o));
  // R7
  hammer_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hammer_o) |-> ($past(ready_o) && $past(fire_i)));
  // R9
  feed_after_hammer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hammer_o) |-> feed_o);
  // R9
  line_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(feed_o) |-> (wheel_o == '0 && !ready_o && !hammer_o));
endmodule

// File: tb/wheel_printer_seq_tb.sv
`timescale 1ns/1ps
module wheel_printer_seq_tb;
  localparam int HCYC = 4;
  localparam int FCYC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] step_div;
  logic       block, fire;
  logic       step_w, ready_w, hammer_w, feed_w;
  logic [2:0] wheel_w;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  int tgt[8];
  int seen[8];
  int div_val = 3;
  int cyc = 0;
  int due = 0;
  bit prev_spin = 0;
  int prev_wheel = 0;
  bit force_blk = 0;

  always #2.5 clk = ~clk;
  assign step_div = 8'(div_val);

  wheel_printer_seq #(.HAMMER_CYC(HCYC), .FEED_CYC(FCYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .step_div_i(step_div), .block_i(block),
    .fire_i(fire), .step_o(step_w), .wheel_o(wheel_w), .ready_o(ready_w),
    .hammer_o(hammer_w), .feed_o(feed_w)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: expected step items for one line
  task automatic load_line(input int t [8], input int dv);
    div_val = dv;
    for (int w = 0; w < 8; w++) begin
      tgt[w] = t[w];
      for (int k = 0; k < ((t[w] > 12) ? 12 : t[w]); k++) exp_q.push_back(w);
    end
  endtask

  // monitor: pops expected items, drives block by pulse count
  initial begin
    block = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        prev_spin = 0;
        block = 1'b0;
      end else begin
        bit spin;
        spin = !ready_w && !hammer_w && !feed_w;
        if (spin && (!prev_spin || int'(wheel_w) != prev_wheel)) begin
          due = cyc + div_val;
          seen[wheel_w] = 0;
        end
        if (step_w) begin
          if (exp_q.size() == 0) chk(0, "R6 unexpected step", int'(wheel_w), -1);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(wheel_w) == e, "R5/R3/R4 step wheel", int'(wheel_w), e);
          end
          chk(cyc == due, "R2 step timing", cyc, due);
          due = cyc + div_val + 1;
          if (spin) seen[wheel_w]++;
        end
        block = force_blk || (spin && seen[wheel_w] == tgt[wheel_w]);
        prev_spin = spin;
        prev_wheel = int'(wheel_w);
      end
    end
  end

  task automatic wait_ready(input string tag);
    int n = 0;
    while (!ready_w && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(ready_w, tag, int'(ready_w), 1);
    chk(exp_q.size() == 0, "R3/R4 pulse count per line", exp_q.size(), 0);
    chk(wheel_w == 3'd7, "R6 wheel held at last", int'(wheel_w), 7);
  endtask

  task automatic fire_line();
    int h = 0;
    int f = 0;
    @(negedge clk); #1 fire = 1'b1;
    @(negedge clk);
    chk(hammer_w && !ready_w, "R8 hammer starts", int'(hammer_w), 1);
    #1 fire = 1'b0;
    while (hammer_w && h < 100) begin
      h++;
      @(negedge clk);
    end
    chk(h == HCYC, "R8 hammer length", h, HCYC);
    chk(feed_w, "R9 feed follows hammer", int'(feed_w), 1);
    while (feed_w && f < 100) begin
      f++;
      @(negedge clk);
    end
    chk(f == FCYC, "R9 feed length", f, FCYC);
    chk(wheel_w == 3'd0 && !ready_w && !hammer_w, "R9 restart at wheel 0", int'(wheel_w), 0);
  endtask

  initial begin
    int t1 [8] = '{3, 0, 12, 1, 5, 11, 2, 7};
    int t2 [8] = '{12, 12, 0, 0, 4, 6, 1, 9};
    int t3 [8] = '{0, 0, 0, 0, 0, 0, 0, 0};
    fire = 1'b0;
    load_line(t1, 3);
    repeat (3) @(negedge clk);
    chk(!step_w && !ready_w && !hammer_w && !feed_w && wheel_w == 0, "R1 reset state",
        int'({step_w, ready_w, hammer_w, feed_w}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!step_w && !ready_w && !hammer_w && !feed_w && wheel_w == 0, "R1 after release",
        int'({step_w, ready_w, hammer_w, feed_w}), 0);
    wait_ready("R6 ready after line 1");

    // R6: block ignored while waiting
    @(negedge clk); #1 force_blk = 1'b1;
    repeat (8) @(negedge clk);
    chk(ready_w && wheel_w == 3'd7, "R6 block ignored in ready", int'(ready_w), 1);
    #1 force_blk = 1'b0;

    load_line(t2, 2);
    fire_line();

    // R7: fire while spinning has no effect
    repeat (2) @(negedge clk);
    #1 fire = 1'b1;
    @(negedge clk); #1 fire = 1'b0;
    @(negedge clk);
    chk(!hammer_w && !ready_w, "R7 fire ignored while spinning", int'(hammer_w), 0);
    wait_ready("R6 ready after line 2");

    load_line(t3, 5);
    fire_line();
    wait_ready("R3 ready after all-blocked line");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule